// File: doc/BRIEF.md
# Ring-Cascaded FIFO Slice Controller

This block is one slice of a FIFO that can be made deeper by chaining identical slices in a ring. Every slice holds a small local store. All slices see the same write strobe, write data and read strobe. Each slice's `ring_out_n` feeds the next slice's `ring_in_n`. A slice stores or returns a word only while it holds the matching token. It owns the write token and the read token separately. When it uses its last location it passes that token to the next slice with a one-cycle low pulse on `ring_out_n`. The read data of all slices are ORed together outside the block, because an idle slice drives zero.

While reset is held low, each slice picks its role from two pins. If `ring_in_n` is low, the slice runs on its own as a plain FIFO. In that role `ring_out_n` becomes an active-low more-than-half-full indicator and `lead_rt_n` becomes a rewind request. If `ring_in_n` is high, the slice is part of a ring: `lead_rt_n` low makes it the head, which starts with both tokens, and `lead_rt_n` high makes it a follower. Each slice reports local full and empty flags only while it holds the relevant token. The ring's overall flags are then formed by ANDing the active-low flags of all slices.

Top module: `casc_slice`

## Requirements
- R1: The role is captured on every clock edge while `rst_n` is low and then held. `ring_in_n`=0 selects solo. `ring_in_n`=1 with `lead_rt_n`=0 selects head. `ring_in_n`=1 with `lead_rt_n`=1 selects follower.
- R2: While `rst_n` is low, `ring_out_n` is 1 in every role. This lets the next slice of a ring see `ring_in_n` high during reset.
- R3: After reset, a head or solo slice holds both the write token and the read token, and a follower holds neither. The store is empty, and each local position is 0.
- R4: A write is accepted (`wr_sel`=1) only by the slice holding the write token. A read is accepted (`rd_sel`=1) only by the slice holding the read token. In a ring, at most one slice accepts any write and at most one accepts any read.
- R5: In a ring role, when a slice accepts a write into its last location (index DEPTH-1), `ring_out_n` goes 0 in that same cycle. The slice then gives up the write token, and its next write goes to location 0.
- R6: In a ring role, when a slice accepts a read from its last location, `ring_out_n` goes 0 in that same cycle. The slice then gives up the read token.
- R7: In a ring role, `ring_in_n`=0 together with `wr_req`=1 gives the slice the write token for the next cycle. `ring_in_n`=0 together with `rd_req`=1 and `wr_req`=0 gives it the read token for the next cycle.
- R8: When `wr_req` and `rd_req` are both 1 in one cycle, only the write is considered. The read is ignored: no slice accepts it and no word is consumed.
- R9: Words come out in the order they were written across the whole ring. The word appears on `rd_data` with `rd_valid`=1 in the cycle after the accepted read. Otherwise `rd_data` is 0 and `rd_valid` is 0.
- R10: `full_n` is 0 exactly when the slice is full and holds the write token, and a write is then ignored. `empty_n` is 0 exactly when the slice is empty and holds the read token, and a read is then ignored.
- R11: In solo role, `ring_out_n` is 0 exactly when more than DEPTH/2 words are stored.
- R12: In solo role, a cycle with `lead_rt_n`=0 moves the read position back to location 0. The stored count becomes the write position, and any strobe in that cycle is ignored. In ring roles, `lead_rt_n` has no effect after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; role is sampled while low |
| wr_req | input | 1 | Shared write strobe |
| wr_data | input | DATA_W | Shared write data |
| rd_req | input | 1 | Shared read strobe |
| rd_data | output | DATA_W | Read word, zero when not valid (OR-mergeable) |
| rd_valid | output | 1 | This slice returned a word this cycle |
| ring_in_n | input | 1 | Token pulse from previous slice; role select at reset |
| ring_out_n | output | 1 | Token pulse to next slice; half-full (active low) in solo role |
| lead_rt_n | input | 1 | Head select at reset; rewind request in solo role |
| full_n | output | 1 | Active-low: full while holding the write token |
| empty_n | output | 1 | Active-low: empty while holding the read token |
| wr_sel | output | 1 | This slice accepts the current write |
| rd_sel | output | 1 | This slice accepts the current read |

## Verification
A ring of three 4-word slices is first filled with twelve writes and then drained with twelve reads. This block run separates a correct token hand-off from an off-by-one on the last location, because each of the six pulses has to land on a fixed write or read. A write is then tried on the full ring, and a read that coincides with a write, and a read on the empty ring. These show whether the full and empty gating and the write priority hold. An interleaved pattern follows, in which the read token trails the write token by less than one slice, so that both tokens live in different slices at once. A separate solo slice is filled past half. It is read once, rewound with a write strobe pending, and then read again. This shows apart the threshold of the half-full output, the rewind count, and the suppression of the strobe during a rewind.

// File: rtl/casc_pkg.sv
package casc_pkg;

  typedef enum logic [1:0] {
    MODE_SOLO   = 2'd0,
    MODE_HEAD   = 2'd1,
    MODE_FOLLOW = 2'd2
  } casc_mode_e;

  // Role chosen from the pin levels seen while reset is held.
  function automatic casc_mode_e pick_mode(input logic ring_in_n, input logic lead_n);
    if (!ring_in_n)  return MODE_SOLO;
    else if (!lead_n) return MODE_HEAD;
    else              return MODE_FOLLOW;
  endfunction

  // Position after the current one, wrapping at the end of the store.
  function automatic int unsigned wrap_inc(input int unsigned pos, input int unsigned depth);
    return (pos + 1 >= depth) ? 0 : pos + 1;
  endfunction

  // More than half of the store occupied.
  function automatic logic above_half(input int unsigned fill, input int unsigned depth);
    return fill > depth / 2;
  endfunction

endpackage

// File: rtl/casc_mode_latch.sv
module casc_mode_latch
  import casc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  casc_mode_e pin_mode,
  output casc_mode_e mode
);

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= pin_mode;
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (!rst_n || $stable(mode)));  // R1

endmodule

// File: rtl/casc_token.sv
module casc_token
  import casc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  casc_mode_e pin_mode,
  input  casc_mode_e mode,
  input  logic       wr_pass,
  input  logic       rd_pass,
  input  logic       take_w,
  input  logic       take_r,
  output logic       wtok,
  output logic       rtok
);

  logic start_owner;
  assign start_owner = (pin_mode != MODE_FOLLOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wtok <= start_owner;
      rtok <= start_owner;
    end else if (mode == MODE_SOLO) begin
      wtok <= 1'b1;
      rtok <= 1'b1;
    end else begin
      if (wr_pass)     wtok <= 1'b0;
      else if (take_w) wtok <= 1'b1;
      if (rd_pass)     rtok <= 1'b0;
      else if (take_r) rtok <= 1'b1;
    end
  end

  AST_SOLO_OWNS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SOLO) |-> (wtok && rtok));  // R3

  AST_WTOK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass |=> !wtok);  // R5

  AST_RTOK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pass |=> !rtok);  // R6

endmodule

// File: rtl/casc_store.sv
module casc_store
  import casc_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_fire,
  input  logic              rewind,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [CW-1:0]     fill,
  output logic              full,
  output logic              empty,
  output logic              wr_at_last,
  output logic              rd_at_last
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wpos, rpos;
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wpos] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpos     <= '0;
      rpos     <= '0;
      fill     <= '0;
      rd_valid <= 1'b0;
      out_q    <= '0;
    end else if (rewind) begin
      rpos     <= '0;
      fill     <= CW'(wpos);
      rd_valid <= 1'b0;
    end else begin
      if (wr_fire) wpos <= AW'(wrap_inc(32'(wpos), DEPTH));
      if (rd_fire) begin
        rpos  <= AW'(wrap_inc(32'(rpos), DEPTH));
        out_q <= mem[rpos];
      end
      rd_valid <= rd_fire;
      case ({wr_fire, rd_fire})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign rd_data    = rd_valid ? out_q : '0;
  assign full       = (fill == CW'(DEPTH));
  assign empty      = (fill == '0);
  assign wr_at_last = (wpos == LAST);
  assign rd_at_last = (rpos == LAST);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));  // R10

  AST_NO_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));  // R9

endmodule

// File: rtl/casc_slice.sv
module casc_slice
  import casc_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              ring_in_n,
  output logic              ring_out_n,
  input  logic              lead_rt_n,
  output logic              full_n,
  output logic              empty_n,
  output logic              wr_sel,
  output logic              rd_sel
);

  casc_mode_e    pin_mode, mode;
  logic          solo, rewind;
  logic          wtok, rtok;
  logic          full, empty, wr_at_last, rd_at_last;
  logic          wr_pass, rd_pass, take_w, take_r;
  logic [CW-1:0] fill;

  assign pin_mode = pick_mode(ring_in_n, lead_rt_n);

  casc_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_mode (pin_mode),
    .mode     (mode)
  );

  assign solo   = (mode == MODE_SOLO);
  assign rewind = solo && !lead_rt_n;

  // Local accept decisions; write wins over a read in the same cycle.
  assign wr_sel = wr_req && wtok && !full && !rewind;
  assign rd_sel = rd_req && !wr_req && rtok && !empty && !rewind;

  // Hand-off and pick-up events of the ring.
  assign wr_pass = !solo && wr_sel && wr_at_last;
  assign rd_pass = !solo && rd_sel && rd_at_last;
  assign take_w  = !solo && !ring_in_n && wr_req;
  assign take_r  = !solo && !ring_in_n && rd_req && !wr_req;

  casc_token u_token (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_mode (pin_mode),
    .mode     (mode),
    .wr_pass  (wr_pass),
    .rd_pass  (rd_pass),
    .take_w   (take_w),
    .take_r   (take_r),
    .wtok     (wtok),
    .rtok     (rtok)
  );

  casc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_sel),
    .wr_data    (wr_data),
    .rd_fire    (rd_sel),
    .rewind     (rewind),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .fill       (fill),
    .full       (full),
    .empty      (empty),
    .wr_at_last (wr_at_last),
    .rd_at_last (rd_at_last)
  );

  always_comb begin
    if (!rst_n)    ring_out_n = 1'b1;
    else if (solo) ring_out_n = !above_half(32'(fill), DEPTH);
    else           ring_out_n = !(wr_pass || rd_pass);
  end

  assign full_n  = !(full && wtok);
  assign empty_n = !(empty && rtok);

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> rd_valid);  // R9

  AST_ONE_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rd_req) |=> !rd_valid);  // R8

endmodule

// File: tb/tb_casc_slice.sv
module tb_casc_slice;

  localparam int W = 9;
  localparam int D = 4;
  localparam int N = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, wr_req, rd_req;
  logic [W-1:0] wdat;
  logic [N-1:0] rout, wsel, rsel, rval, fulln, emptyn;
  logic [W-1:0] rd0, rd1, rd2, merged;

  logic         s_wr, s_rd, s_rt, s_out, s_val, s_full_n, s_empty_n, s_wsel, s_rsel;
  logic [W-1:0] s_wdat, s_rdat;

  int total = 0, bad = 0;
  int wt, wl, rt, rl;
  int cnt [N];
  logic [W-1:0] q [$];

  casc_slice #(.DATA_W(W), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wdat), .rd_req(rd_req),
    .rd_data(rd0), .rd_valid(rval[0]), .ring_in_n(rout[2]), .ring_out_n(rout[0]),
    .lead_rt_n(1'b0), .full_n(fulln[0]), .empty_n(emptyn[0]),
    .wr_sel(wsel[0]), .rd_sel(rsel[0]));

  casc_slice #(.DATA_W(W), .DEPTH(D)) u_s1 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wdat), .rd_req(rd_req),
    .rd_data(rd1), .rd_valid(rval[1]), .ring_in_n(rout[0]), .ring_out_n(rout[1]),
    .lead_rt_n(1'b1), .full_n(fulln[1]), .empty_n(emptyn[1]),
    .wr_sel(wsel[1]), .rd_sel(rsel[1]));

  casc_slice #(.DATA_W(W), .DEPTH(D)) u_s2 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wdat), .rd_req(rd_req),
    .rd_data(rd2), .rd_valid(rval[2]), .ring_in_n(rout[1]), .ring_out_n(rout[2]),
    .lead_rt_n(1'b1), .full_n(fulln[2]), .empty_n(emptyn[2]),
    .wr_sel(wsel[2]), .rd_sel(rsel[2]));

  casc_slice #(.DATA_W(W), .DEPTH(D)) u_solo (
    .clk(clk), .rst_n(rst_n), .wr_req(s_wr), .wr_data(s_wdat), .rd_req(s_rd),
    .rd_data(s_rdat), .rd_valid(s_val), .ring_in_n(1'b0), .ring_out_n(s_out),
    .lead_rt_n(s_rt), .full_n(s_full_n), .empty_n(s_empty_n),
    .wr_sel(s_wsel), .rd_sel(s_rsel));

  assign merged = rd0 | rd1 | rd2;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_full_n();
    logic [N-1:0] v;
    for (int s = 0; s < N; s++) v[s] = !(s == wt && cnt[s] == D);
    return v;
  endfunction

  function automatic logic [N-1:0] exp_empty_n();
    logic [N-1:0] v;
    for (int s = 0; s < N; s++) v[s] = !(s == rt && cnt[s] == 0);
    return v;
  endfunction

  // One ring cycle with the given strobes; the model predicts every port.
  task automatic ring_op(input bit w, input bit r, input logic [W-1:0] d);
    bit wacc, racc;
    logic [N-1:0] ring_exp;
    logic [W-1:0] want;
    @(negedge clk);
    wr_req = w; rd_req = r; wdat = d;
    wacc = w && cnt[wt] < D;
    racc = r && !w && cnt[rt] > 0;
    #1;
    chk(wsel == (wacc ? N'(1 << wt) : '0), "R4", "write select", wsel, wacc ? (1 << wt) : 0);
    chk(rsel == (racc ? N'(1 << rt) : '0), "R8", "read select", rsel, racc ? (1 << rt) : 0);
    ring_exp = '1;
    if (wacc && wl == D - 1) ring_exp[wt] = 1'b0;  // R5
    if (racc && rl == D - 1) ring_exp[rt] = 1'b0;  // R6
    chk(rout == ring_exp, "R5", "ring pulses", rout, ring_exp);
    @(posedge clk);
    #1;
    wr_req = 1'b0; rd_req = 1'b0;
    if (wacc) begin
      q.push_back(d);
      cnt[wt]++;
      if (wl == D - 1) begin wl = 0; wt = (wt + 1) % N; end else wl++;
    end
    if (racc) begin
      want = q.pop_front();
      chk(merged == want && rval == N'(1 << rt), "R9", "read word", merged, want);
      cnt[rt]--;
      if (rl == D - 1) begin rl = 0; rt = (rt + 1) % N; end else rl++;
    end else begin
      chk(rval == '0 && merged == '0, "R10", "no read output", rval, 0);
    end
    chk(fulln == exp_full_n(), "R10", "full flags", fulln, exp_full_n());
    chk(emptyn == exp_empty_n(), "R7", "empty flags / read token", emptyn, exp_empty_n());
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_req = 0; rd_req = 0; wdat = '0;
    s_wr = 0; s_rd = 0; s_rt = 1'b1; s_wdat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rout == '1 && s_out, "R2", "ring out during reset", {s_out, rout}, 4'hf);
    rst_n = 1'b1;
    #1;
    wt = 0; wl = 0; rt = 0; rl = 0;
    for (int s = 0; s < N; s++) cnt[s] = 0;
    q.delete();
    chk(emptyn == 3'b110, "R3", "only head holds read token", emptyn, 3'b110);
    chk(fulln == 3'b111, "R1", "no full after reset", fulln, 3'b111);
    chk(!s_empty_n && s_out, "R1", "solo role empty, not half", {s_empty_n, s_out}, 1);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < N * D; i++) ring_op(1, 0, W'(9'h40 + i));
    chk(fulln == 3'b110, "R10", "ring full at head", fulln, 3'b110);
    ring_op(1, 0, 9'h1aa);         // R10 write on full ring ignored
    ring_op(1, 1, 9'h1bb);         // R8 read beside write ignored
    for (int i = 0; i < N * D; i++) ring_op(0, 1, '0);
    chk(emptyn == 3'b110, "R6", "read token back at head", emptyn, 3'b110);
    ring_op(0, 1, '0);             // R10 read on empty ring ignored
  endtask

  task automatic t_interleave();
    for (int i = 0; i < 5; i++) ring_op(1, 0, W'(9'h80 + i));
    for (int i = 0; i < 3; i++) ring_op(0, 1, '0);
    for (int i = 0; i < 2; i++) ring_op(1, 0, W'(9'h90 + i));
    ring_op(1, 1, 9'h99);          // R8 write wins over read
    for (int i = 0; i < 5; i++) ring_op(0, 1, '0);
    chk(q.size() == 0, "R9", "model drained", q.size(), 0);
  endtask

  task automatic solo_cycle(input bit w, input bit r, input bit rt_n, input logic [W-1:0] d);
    @(negedge clk);
    s_wr = w; s_rd = r; s_rt = rt_n; s_wdat = d;
    @(posedge clk);
    #1;
    s_wr = 0; s_rd = 0; s_rt = 1'b1;
  endtask

  task automatic t_solo();
    solo_cycle(1, 0, 1, 9'h011);
    solo_cycle(1, 0, 1, 9'h022);
    chk(s_out == 1'b1, "R11", "two words not above half", s_out, 1);
    solo_cycle(1, 0, 1, 9'h033);
    chk(s_out == 1'b0, "R11", "three words above half", s_out, 0);
    solo_cycle(0, 1, 1, '0);
    chk(s_val && s_rdat == 9'h011, "R9", "solo first word", s_rdat, 9'h011);
    chk(s_out == 1'b1, "R11", "two left not above half", s_out, 1);
    solo_cycle(1, 0, 0, 9'h0ee);   // R12 rewind, write strobe ignored
    chk(!s_val && s_out == 1'b0, "R12", "rewind restores three words", s_out, 0);
    solo_cycle(0, 1, 1, '0);
    chk(s_val && s_rdat == 9'h011, "R12", "reread word 0", s_rdat, 9'h011);
    solo_cycle(0, 1, 1, '0);
    chk(s_rdat == 9'h022, "R12", "reread word 1", s_rdat, 9'h022);
    solo_cycle(0, 1, 1, '0);
    chk(s_rdat == 9'h033, "R12", "reread word 2", s_rdat, 9'h033);
    chk(!s_empty_n, "R12", "empty after reread, rewind write dropped", s_empty_n, 0);
  endtask

  bit done = 0;

  initial begin
    t_reset();
    t_fill_drain();
    t_interleave();   // head lead_rt_n held low all along: R12 no effect in ring
    t_solo();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule